// File: doc/BRIEF.md
# Accelerator Control and Status Front-End

This block is the register-facing shell of an operation-driven arithmetic accelerator. Software reaches it through a simple single-cycle read/write port that holds three 32-bit words. The control word holds an enable, a start strobe, a 6-bit operation code and four interrupt enables. The status word reports readiness, activity and four sticky event flags. The third word is write-one-to-clear and acknowledges those flags. The compute engine is outside the block. The front-end gives it a one-cycle start pulse together with the operation code, and waits for a completion pulse from it.

Operation codes are checked in two places. The first check runs when the code field is written with the enable set. The second runs when a start is requested. A restricted mode, selected by an input pin, accepts only one code. A start that carries an illegal code never reaches the engine. The block shows busy for a short, fixed time, then drops busy and raises the operation-error flag. The four flags, each ANDed with its own enable, are ORed into a single interrupt line.

Top module: `acc_ctl_front`

## Requirements
- R1: After reset the control word reads 0, busy_o, irq_o and eng_start_o are 0, all four flags are 0, and the status word holds only the readiness bit.
- R2: The control word is at byte 0. Enable is bit 0, start is bit 1 and always reads 0, the operation code is bits 13:8, and the interrupt enables for end, RAM error, address error and operation error are bits 17, 19, 20 and 21. All of these except start read back as written.
- R3: The status word is at byte 4. Bit 0 is 1 only while both init_rdy_i and rng_ok_i are 1. Bit 16 mirrors busy. The end, RAM-error, address-error and operation-error flags are bits 17, 19, 20 and 21.
- R4: By default the legal codes are 0x00 to 0x0F and 0x24 to 0x26. A control write with enable 1 that carries a different, illegal code leaves the held code unchanged and sets the operation-error flag. A write with enable 0 stores any code without a check.
- R5: While lim_mode_i is 1, a control write with enable 1 and a new code other than 0x26 is dropped and sets the operation-error flag.
- R6: A control write with enable 1 and start 1 while idle, whose resulting code is legal, makes busy_o 1 from the next cycle on. It also gives a one-cycle eng_start_o pulse with that code on eng_opcode_o.
- R7: While an operation runs, an eng_done_i pulse clears busy at the next edge and sets the end flag.
- R8: Start has no effect while busy (no second engine pulse) and no effect when the write carries enable 0.
- R9: A start whose resulting code is illegal raises busy for ABORT_CYC cycles (default 2) with no engine pulse. Busy then returns to 0 and the operation-error flag is set.
- R10: Writing 1 to bit 17, 19, 20 or 21 of the word at byte 8 clears the matching flag, and writing 0 leaves it alone.
- R11: A one-cycle pulse on ram_err_i or addr_err_i sets the RAM-error or address-error flag. A set wins over a clear in the same cycle.
- R12: irq_o is 1 exactly when some flag is 1 and its interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| lim_mode_i | input | 1 | Restricted mode: only one code is accepted |
| init_rdy_i | input | 1 | Accelerator initialisation done |
| rng_ok_i | input | 1 | Random source healthy |
| eng_done_i | input | 1 | Engine completion pulse |
| ram_err_i | input | 1 | Operand RAM error pulse |
| addr_err_i | input | 1 | Address error pulse |
| eng_start_o | output | 1 | One-cycle engine start pulse |
| eng_opcode_o | output | OP_W | Code issued with the start pulse |
| busy_o | output | 1 | Operation or abort in progress |
| irq_o | output | 1 | Combined interrupt |

## Verification
A corrupted held code shows up on the very next control read-back. It also shows up one write later, because a legal write is then rejected, or an illegal one accepted, and the operation-error bit reports it. A sequencer stuck in its run or abort state keeps busy high and swallows later starts, so the next start produces no engine pulse within one cycle. A flag that fails to set or clear shows in the status word and on irq_o in the cycle after the event.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;
  localparam int unsigned FLAG_N = 4;
  // flag index order inside the block
  localparam int unsigned FL_END = 0;
  localparam int unsigned FL_RAM = 1;
  localparam int unsigned FL_ADR = 2;
  localparam int unsigned FL_OPE = 3;
  // bit position of each flag / enable in the status, control and clear words
  localparam int unsigned FLAG_POS [FLAG_N] = '{17, 19, 20, 21};
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned START_BIT = 1;
  localparam int unsigned OP_LSB    = 8;
  localparam int unsigned RDY_BIT   = 0;
  localparam int unsigned BUSY_BIT  = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_ABORT = 2'd2
  } seq_st_t;
endpackage

// File: rtl/acc_op_check.sv
module acc_op_check #(
  parameter int unsigned OP_W = 6,
  parameter logic [2**OP_W-1:0] LEGAL_MASK = '1,
  parameter logic [OP_W-1:0] LIM_OP = '0
) (
  input  logic [OP_W-1:0] wr_op_i,
  input  logic [OP_W-1:0] held_op_i,
  input  logic            lim_i,
  output logic            wr_ok_o,
  output logic            held_ok_o
);
  function automatic logic code_allowed(input logic [OP_W-1:0] op, input logic lim);
    if (lim) return op == LIM_OP;
    return LEGAL_MASK[op];
  endfunction

  assign wr_ok_o   = code_allowed(wr_op_i, lim_i);
  assign held_ok_o = code_allowed(held_op_i, lim_i);
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_ctl_pkg::*;
#(
  parameter int unsigned ABORT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_go_i,
  input  logic start_bad_i,
  input  logic eng_done_i,
  output logic busy_o,
  output logic eng_start_o,
  output logic done_evt_o,
  output logic abort_evt_o
);
  localparam int unsigned CNT_W = $clog2(ABORT_CYC + 1);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o      = (st_q != SEQ_IDLE);
  assign done_evt_o  = (st_q == SEQ_RUN) && eng_done_i;
  assign abort_evt_o = (st_q == SEQ_ABORT) && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      cnt_q       <= '0;
      eng_start_o <= 1'b0;
    end else begin
      eng_start_o <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start_go_i) begin
            st_q        <= SEQ_RUN;
            eng_start_o <= 1'b1;
          end else if (start_bad_i) begin
            st_q  <= SEQ_ABORT;
            cnt_q <= CNT_W'(ABORT_CYC);
          end
        end
        SEQ_RUN: begin
          if (eng_done_i) st_q <= SEQ_IDLE;
        end
        SEQ_ABORT: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acc_flag_bank.sv
module acc_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[g] <= 1'b0;
      else if (set_i[g]) flags_o[g] <= 1'b1;
      else if (clr_i[g]) flags_o[g] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & ie_i);
endmodule

// File: rtl/acc_ctl_front.sv
module acc_ctl_front
  import acc_ctl_pkg::*;
#(
  parameter int unsigned OP_W = 6,
  parameter logic [2**OP_W-1:0] LEGAL_MASK = 64'h0000_0070_0000_FFFF,
  parameter logic [OP_W-1:0] LIM_OP = 6'h26,
  parameter int unsigned ABORT_CYC = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lim_mode_i,
  input  logic              init_rdy_i,
  input  logic              rng_ok_i,
  input  logic              eng_done_i,
  input  logic              ram_err_i,
  input  logic              addr_err_i,
  output logic              eng_start_o,
  output logic [OP_W-1:0]   eng_opcode_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8);

  // held control state
  logic              en_q;
  logic [OP_W-1:0]   op_q;
  logic [FLAG_N-1:0] ie_q;
  logic [OP_W-1:0]   eng_op_q;

  // decoded bus events
  logic ctrl_wr, clr_wr;
  logic new_en;
  logic [OP_W-1:0] new_op;
  logic [FLAG_N-1:0] new_ie, clr_bits;

  // named internal events
  logic wr_ok, held_ok;
  logic op_wr_err;
  logic [OP_W-1:0] op_next;
  logic op_next_ok;
  logic start_req, start_go, start_bad;
  logic done_evt, abort_evt;
  logic [FLAG_N-1:0] flag_set, flags;
  logic init_ok;
  logic [31:0] ctrl_rd, stat_rd;
  logic wdata_unused;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign clr_wr  = bus_sel && bus_wr && (bus_addr == OFS_CLR);
  assign new_en  = bus_wdata[EN_BIT];
  assign new_op  = bus_wdata[OP_LSB +: OP_W];

  for (genvar g = 0; g < FLAG_N; g++) begin : g_bits
    assign new_ie[g]   = bus_wdata[FLAG_POS[g]];
    assign clr_bits[g] = clr_wr && bus_wdata[FLAG_POS[g]];
  end

  assign wdata_unused = ^{bus_wdata[31:22], bus_wdata[18], bus_wdata[16:14], bus_wdata[7:2]};

  acc_op_check #(
    .OP_W(OP_W), .LEGAL_MASK(LEGAL_MASK), .LIM_OP(LIM_OP)
  ) i_op_check (
    .wr_op_i  (new_op),
    .held_op_i(op_q),
    .lim_i    (lim_mode_i),
    .wr_ok_o  (wr_ok),
    .held_ok_o(held_ok)
  );

  // a checked write only rejects a code that differs from the held one
  assign op_wr_err  = ctrl_wr && new_en && (new_op != op_q) && !wr_ok;
  assign op_next    = (ctrl_wr && !op_wr_err) ? new_op : op_q;
  assign op_next_ok = (ctrl_wr && !op_wr_err) ? wr_ok : held_ok;

  assign start_req = ctrl_wr && bus_wdata[START_BIT] && new_en && !busy_o;
  assign start_go  = start_req && op_next_ok;
  assign start_bad = start_req && !op_next_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      op_q     <= '0;
      ie_q     <= '0;
      eng_op_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q <= new_en;
        ie_q <= new_ie;
        op_q <= op_next;
      end
      if (start_go) eng_op_q <= op_next;
    end
  end

  assign eng_opcode_o = eng_op_q;

  acc_seq #(.ABORT_CYC(ABORT_CYC)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_go_i (start_go),
    .start_bad_i(start_bad),
    .eng_done_i (eng_done_i),
    .busy_o     (busy_o),
    .eng_start_o(eng_start_o),
    .done_evt_o (done_evt),
    .abort_evt_o(abort_evt)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FL_END] = done_evt;
    flag_set[FL_RAM] = ram_err_i;
    flag_set[FL_ADR] = addr_err_i;
    flag_set[FL_OPE] = op_wr_err || abort_evt;
  end

  acc_flag_bank #(.N(FLAG_N)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (clr_bits),
    .ie_i   (ie_q),
    .flags_o(flags),
    .irq_o  (irq_o)
  );

  assign init_ok = init_rdy_i && rng_ok_i;

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[EN_BIT]             = en_q;
    ctrl_rd[OP_LSB +: OP_W]     = op_q;
    stat_rd                     = '0;
    stat_rd[RDY_BIT]            = init_ok;
    stat_rd[BUSY_BIT]           = busy_o;
    for (int i = 0; i < FLAG_N; i++) begin
      ctrl_rd[FLAG_POS[i]] = ie_q[i];
      stat_rd[FLAG_POS[i]] = flags[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == OFS_CTRL)      bus_rdata = ctrl_rd;
      else if (bus_addr == OFS_STAT) bus_rdata = stat_rd;
    end
  end
endmodule

// File: rtl/acc_ctl_chk.sv
module acc_ctl_chk #(
  parameter int unsigned OP_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            eng_start_o,
  input logic            rng_ok_i,
  input logic            init_ok,
  input logic [3:0]      flags,
  input logic [OP_W-1:0] op_q,
  input logic            op_wr_err,
  input logic            abort_evt
);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> busy_o);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> !$past(busy_o));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> (busy_o && !eng_start_o));

  // R7
  settle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (flags[0] || flags[3]));

  // R4
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr_err |=> (op_q == $past(op_q)));

  // R4
  op_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr_err |=> flags[3]);

  // R3
  rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rng_ok_i |-> !init_ok);
endmodule

bind acc_ctl_front acc_ctl_chk #(.OP_W(OP_W)) i_acc_ctl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .eng_start_o(eng_start_o),
  .rng_ok_i   (rng_ok_i),
  .init_ok    (init_ok),
  .flags      (flags),
  .op_q       (op_q),
  .op_wr_err  (op_wr_err),
  .abort_evt  (abort_evt)
);

// File: tb/test_acc_ctl_front.sv
`timescale 1ns/1ps
module test_acc_ctl_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        lim_mode_i, init_rdy_i, rng_ok_i, eng_done_i, ram_err_i, addr_err_i;
  logic        eng_start_o, busy_o, irq_o;
  logic [5:0]  eng_opcode_o;

  int vec = 0;
  int errs = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  acc_ctl_front i_acc_ctl_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lim_mode_i(lim_mode_i), .init_rdy_i(init_rdy_i), .rng_ok_i(rng_ok_i),
    .eng_done_i(eng_done_i), .ram_err_i(ram_err_i), .addr_err_i(addr_err_i),
    .eng_start_o(eng_start_o), .eng_opcode_o(eng_opcode_o),
    .busy_o(busy_o), .irq_o(irq_o)
  );

  localparam logic [31:0] B_EN  = 32'h1;
  localparam logic [31:0] B_GO  = 32'h2;
  localparam logic [31:0] B_END = 32'h1 << 17;
  localparam logic [31:0] B_RAM = 32'h1 << 19;
  localparam logic [31:0] B_ADR = 32'h1 << 20;
  localparam logic [31:0] B_OPE = 32'h1 << 21;
  localparam logic [31:0] B_BSY = 32'h1 << 16;
  localparam logic [31:0] ALLF  = B_END | B_RAM | B_ADR | B_OPE;

  function automatic logic ok_code(input logic [5:0] op, input logic lim);
    if (lim) return op == 6'd38;
    return (op < 6'd16) || (op >= 6'd36 && op <= 6'd38);
  endfunction

  function automatic logic [31:0] opf(input logic [5:0] op);
    return {18'd0, op, 8'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_p(input logic [3:0] a, input logic [31:0] d, input logic rp, input logic ap);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    ram_err_i = rp; addr_err_i = ap;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ram_err_i = 1'b0; addr_err_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_p(a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0]  m_op;
    logic [31:0] m_ie, m_fl;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    lim_mode_i = 0; init_rdy_i = 1; rng_ok_i = 1; eng_done_i = 0;
    ram_err_i = 0; addr_err_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, rv); check("R1 ctrl", rv, 32'h0);
    rd(4'h4, rv); check("R1 status", rv, 32'h1);
    check("R1 busy/irq/start", {busy_o, irq_o, eng_start_o}, 32'h0);

    // R3 readiness gating
    rng_ok_i = 0; rd(4'h4, rv); check("R3 rng bad", rv, 32'h0);
    rng_ok_i = 1; init_rdy_i = 0; rd(4'h4, rv); check("R3 not init", rv, 32'h0);
    init_rdy_i = 1;

    // R2 field readback
    wr(4'h0, B_EN | opf(6'h05) | B_END | B_RAM);
    rd(4'h0, rv); check("R2 ctrl readback", rv, B_EN | opf(6'h05) | B_END | B_RAM);

    // R4 illegal code with enable set is dropped
    wr(4'h0, B_EN | opf(6'h30));
    rd(4'h0, rv); check("R4 code kept", rv, B_EN | opf(6'h05));
    rd(4'h4, rv); check("R4 operr set", rv, 32'h1 | B_OPE);
    // R10 clear
    wr(4'h8, B_OPE);
    rd(4'h4, rv); check("R10 operr cleared", rv, 32'h1);
    // R4 enable 0 stores unchecked
    wr(4'h0, opf(6'h30));
    rd(4'h0, rv); check("R4 unchecked store", rv, opf(6'h30));

    // R9 bad start: abort after two busy cycles
    wr(4'h0, B_EN | B_GO | opf(6'h30));
    check("R9 busy c1", {eng_start_o, busy_o}, 32'h1);
    rd(4'h4, rv); check("R9 no operr yet", rv, 32'h1 | B_BSY);
    @(negedge clk);
    check("R9 busy c2", {eng_start_o, busy_o}, 32'h1);
    @(negedge clk);
    check("R9 idle", {eng_start_o, busy_o}, 32'h0);
    rd(4'h4, rv); check("R9 operr", rv, 32'h1 | B_OPE);
    wr(4'h8, ALLF);

    // R5 restricted mode
    wr(4'h0, B_EN | opf(6'h26));
    lim_mode_i = 1;
    wr(4'h0, B_EN | opf(6'h05));
    rd(4'h0, rv); check("R5 restricted drop", rv, B_EN | opf(6'h26));
    rd(4'h4, rv); check("R5 operr", rv, 32'h1 | B_OPE);
    lim_mode_i = 0;
    wr(4'h8, B_OPE);

    // R6 legal start
    wr(4'h0, B_EN | B_GO | opf(6'h07));
    check("R6 pulse+busy", {eng_start_o, busy_o}, 32'h3);
    check("R6 opcode", eng_opcode_o, 32'h7);
    rd(4'h0, rv); check("R2 start reads 0", rv, B_EN | opf(6'h07));
    @(negedge clk);
    check("R6 pulse one cycle", {eng_start_o, busy_o}, 32'h1);

    // R8 start while busy ignored
    wr(4'h0, B_EN | B_GO | opf(6'h07));
    check("R8 no restart", {eng_start_o, busy_o}, 32'h1);

    // R7 completion
    eng_done_i = 1; @(negedge clk); eng_done_i = 0;
    check("R7 busy clear", busy_o, 32'h0);
    rd(4'h4, rv); check("R7 end flag", rv, 32'h1 | B_END);
    check("R12 irq off without enable", irq_o, 32'h0);
    wr(4'h0, B_EN | opf(6'h07) | B_END);
    check("R12 irq on", irq_o, 32'h1);
    wr(4'h8, B_END);
    check("R12 irq after clear", irq_o, 32'h0);

    // R8 start with enable 0
    wr(4'h0, B_GO | opf(6'h07));
    check("R8 en0 start", {eng_start_o, busy_o}, 32'h0);

    // R11 pulses and set-over-clear
    wr_p(4'h4, 32'h0, 1'b1, 1'b0);
    rd(4'h4, rv); check("R11 ram flag", rv, 32'h1 | B_RAM);
    wr_p(4'h8, B_RAM | B_ADR, 1'b0, 1'b1);
    rd(4'h4, rv); check("R11 set wins", rv, 32'h1 | B_ADR);
    wr(4'h8, ALLF);

    // random phase
    wr(4'h0, 32'h0);
    m_op = 6'h0;
    for (int i = 0; i < 200; i++) begin
      logic [5:0] op;
      logic lim, rp, ap, en;
      op = 6'($urandom);
      lim = ($urandom % 4) == 0;
      en = ($urandom % 5) != 0;
      rp = ($urandom % 3) == 0;
      ap = ($urandom % 3) == 0;
      m_ie = 32'($urandom) & ALLF;
      lim_mode_i = lim;
      m_fl = 32'h0;
      if (en && op != m_op && !ok_code(op, lim)) m_fl |= B_OPE;
      else m_op = op;
      if (rp) m_fl |= B_RAM;
      if (ap) m_fl |= B_ADR;
      wr_p(4'h0, (en ? B_EN : 32'h0) | opf(op) | m_ie, rp, ap);
      rd(4'h0, rv); check("R4 R5 rand ctrl", rv, (en ? B_EN : 32'h0) | opf(m_op) | m_ie);
      rd(4'h4, rv); check("R11 rand status", rv, 32'h1 | m_fl);
      check("R12 rand irq", irq_o, {31'd0, |(m_fl & m_ie)});
      wr(4'h8, ALLF);
      rd(4'h4, rv); check("R10 rand clear", rv, 32'h1);
    end
    lim_mode_i = 0;
    finish_run();
  end
endmodule